// File: doc/BRIEF.md
# Block Refill Latency Responder

This block stands on the memory side of a cache and answers block refill requests. It reproduces the bus-cycle cost of three ways of organizing main memory, and it models that cost to the exact cycle. A requester offers a block number and an organization code on a valid/ready handshake. The block then spends one address phase. After that it runs one or more access phases followed by data transfers, and it presents the words of the block in ascending offset order on a result bus with a valid strobe. A done strobe marks the final transfer.

In narrow organization, every word pays a full access and then one transfer. In wide organization, one access fetches `WIDE_WORDS` words, and all of them cross the bus together in one transfer. In interleaved organization, all `BANKS` banks start one shared access, and the words then leave one per transfer. Block contents come from a fixed, read-only internal array that is split across the banks. Word `i` of a block lives in bank `i mod BANKS`.

Top module: `mem_refill_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `rsp_done` are 0, and `rsp_data` is all zero.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the next cycle. A request offered while a refill runs is ignored: after the refill ends, no further transfer appears and `req_ready` stays 1.
- R3: Organization code 0 (narrow) presents word k during cycle `ADDR_CYC + (k+1)*(ACCESS_CYC + XFER_CYC)` after the accepting edge. With the defaults, this is cycles 17, 33, 49 and 65.
- R4: Organization code 1 (wide) presents beat j, which holds words `j*WIDE_WORDS` onward, during cycle `ADDR_CYC + (j+1)*(ACCESS_CYC + XFER_CYC)`. With the defaults, this is cycles 17 and 33.
- R5: Organization code 2 (interleaved) pays one access per group of `BANKS` words, and the words of a group then appear on consecutive transfers. With the defaults, this is cycles 17, 18, 19 and 20.
- R6: Word o of block b has the value `((b*BLK_WORDS + o) * 32'h9E3779B1) ^ 32'h0F0F0F0F`, taken over 32 bits. Lane l of `rsp_data` (bits `l*WORD_W` upward) carries offset `beat_offset + l`.
- R7: `rsp_done` is 1 for exactly one cycle per refill, in the cycle of the last transfer, and never without `rsp_valid`.
- R8: Organization code 3 behaves exactly like code 0.
- R9: Lanes above the transfer width are zero. In narrow and interleaved organization, only lane 0 carries data. All of `rsp_data` is zero while `rsp_valid` is 0.
- R10: The organization code and block number are sampled only on acceptance. Changing `req_mode` or `req_blk` during a refill has no effect on its timing or data.
- R11: `req_ready` returns to 1 in the cycle right after the done transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request offered |
| req_ready | output | 1 | Responder idle, request can be taken |
| req_blk | input | BLK_AW | Block number to refill |
| req_mode | input | 2 | Organization: 0 narrow, 1 wide, 2 interleaved, 3 as narrow |
| rsp_valid | output | 1 | Transfer present on `rsp_data` |
| rsp_data | output | WIDE_WORDS*WORD_W | Transfer lanes, lane 0 lowest offset |
| rsp_done | output | 1 | Marks the last transfer of the refill |

## Verification
The same engine is driven with each organization code on different block numbers. Comparing the cycle of every transfer against the closed-form schedule separates narrow, wide and interleaved costs: for example, 65 against 33 against 20 cycles with the defaults. Code 3 must reproduce the narrow schedule exactly. One refill is disturbed by a second request and a mode change part-way through, which exposes any resampling or double acceptance. Because block contents are a function of block number and offset, a wrong bank, row or lane selection shows up as a data mismatch.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

   typedef enum logic [1:0] {
      ORG_NARROW     = 2'd0,
      ORG_WIDE       = 2'd1,
      ORG_INTERLEAVE = 2'd2,
      ORG_SPARE      = 2'd3
   } org_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_ACC  = 2'd2,
      ST_XFER = 2'd3
   } seq_st_e;

   // Fixed block contents, a function of the flat word address.
   function automatic logic [31:0] fill_word(input logic [31:0] wa);
      return (wa * 32'h9E37_79B1) ^ 32'h0F0F_0F0F;
   endfunction

endpackage

// File: rtl/mrf_bank.sv
module mrf_bank
   import mrf_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int ROWS    = 16,
   parameter int ROW_W   = 4,
   parameter int BANK_ID = 0,
   parameter int BANKS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [ROW_W-1:0]  cap_row,
   output logic [WORD_W-1:0] bank_q
);

   logic [WORD_W-1:0] store [ROWS];

   // Storage is loaded with its fixed pattern in reset.
   // The access result is held in bank_q until the next capture.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            store[r] <= WORD_W'(fill_word(32'(r * BANKS + BANK_ID)));
         end
         bank_q <= '0;
      end else if (cap_en) begin
         bank_q <= store[cap_row];
      end
   end

endmodule

// File: rtl/mrf_seq.sv
module mrf_seq
   import mrf_pkg::*;
#(
   parameter int BLK_WORDS  = 4,
   parameter int WIDE_WORDS = 2,
   parameter int BANKS      = 4,
   parameter int ADDR_CYC   = 1,
   parameter int ACCESS_CYC = 15,
   parameter int XFER_CYC   = 1,
   parameter int BLK_AW     = 4,
   parameter int ROW_W      = 4,
   parameter int OFF_W      = 3,
   parameter int CNT_W      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [BLK_AW-1:0] req_blk,
   input  logic [1:0]        req_mode,
   output logic              req_ready,
   output logic              beat_valid,
   output logic              beat_last,
   output logic [OFF_W-1:0]  beat_off,
   output logic [OFF_W-1:0]  beat_lanes,
   output logic              cap_en,
   output logic [ROW_W-1:0]  cap_row
);

   localparam int STRIPES = BLK_WORDS / BANKS;

   seq_st_e           st;
   org_e              org_q;
   logic [BLK_AW-1:0] blk_q;
   logic [CNT_W-1:0]  cnt;
   logic [OFF_W-1:0]  grp_off;
   logic [OFF_W-1:0]  xi;

   logic [CNT_W-1:0]  ph_last;
   logic              phase_end;
   logic [OFF_W-1:0]  grp_sz;
   logic [OFF_W-1:0]  lanes;
   logic [OFF_W-1:0]  xpg;
   logic              last_x;
   logic              last_g;

   // Per-organization shape: words per access, lanes per transfer,
   // and transfers per access group.
   always_comb begin
      case (org_q)
         ORG_WIDE: begin
            grp_sz = OFF_W'(WIDE_WORDS);
            lanes  = OFF_W'(WIDE_WORDS);
            xpg    = OFF_W'(1);
         end
         ORG_INTERLEAVE: begin
            grp_sz = OFF_W'(BANKS);
            lanes  = OFF_W'(1);
            xpg    = OFF_W'(BANKS);
         end
         default: begin
            grp_sz = OFF_W'(1);
            lanes  = OFF_W'(1);
            xpg    = OFF_W'(1);
         end
      endcase
   end

   always_comb begin
      case (st)
         ST_ADDR: ph_last = CNT_W'(ADDR_CYC - 1);
         ST_ACC:  ph_last = CNT_W'(ACCESS_CYC - 1);
         ST_XFER: ph_last = CNT_W'(XFER_CYC - 1);
         default: ph_last = '0;
      endcase
   end

   assign phase_end  = (cnt == ph_last);
   assign last_x     = (xi == xpg - OFF_W'(1));
   assign last_g     = ((grp_off + grp_sz) == OFF_W'(BLK_WORDS));

   assign req_ready  = (st == ST_IDLE);
   assign beat_valid = (st == ST_XFER) && phase_end;
   assign beat_last  = beat_valid && last_x && last_g;
   assign beat_off   = grp_off + xi * lanes;
   assign beat_lanes = lanes;
   assign cap_en     = (st == ST_ACC) && phase_end;
   assign cap_row    = ROW_W'(blk_q) * ROW_W'(STRIPES) + ROW_W'(32'(grp_off) / BANKS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         org_q   <= ORG_NARROW;
         blk_q   <= '0;
         cnt     <= '0;
         grp_off <= '0;
         xi      <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  st      <= ST_ADDR;
                  org_q   <= org_e'(req_mode);
                  blk_q   <= req_blk;
                  cnt     <= '0;
                  grp_off <= '0;
                  xi      <= '0;
               end
            end
            ST_ADDR: begin
               if (phase_end) begin
                  st  <= ST_ACC;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            ST_ACC: begin
               if (phase_end) begin
                  st  <= ST_XFER;
                  cnt <= '0;
                  xi  <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: begin
               if (phase_end) begin
                  cnt <= '0;
                  if (last_x) begin
                     if (last_g) begin
                        st <= ST_IDLE;
                     end else begin
                        st      <= ST_ACC;
                        grp_off <= grp_off + grp_sz;
                     end
                  end else begin
                     xi <= xi + OFF_W'(1);
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
         endcase
      end
   end

   // R2: a taken request makes the responder busy in the next cycle
   p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10: captured organization and block hold for the whole refill
   p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(org_q) && $stable(blk_q)));

   // R11: the responder is free right after the last transfer
   p_done_to_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |=> req_ready);

   // R5: interleaved words of one group leave on consecutive transfers
   p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !last_x && org_q == ORG_INTERLEAVE && XFER_CYC == 1) |=> beat_valid);

   // R6: every transfer points inside the block
   p_off_in_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (32'(beat_off) < BLK_WORDS));

endmodule

// File: rtl/mrf_lane_mux.sv
module mrf_lane_mux #(
   parameter int WORD_W     = 32,
   parameter int WIDE_WORDS = 2,
   parameter int BANKS      = 4,
   parameter int OFF_W      = 3
) (
   input  logic [WORD_W-1:0]            bank_q [BANKS],
   input  logic                         beat_valid,
   input  logic [OFF_W-1:0]             beat_off,
   input  logic [OFF_W-1:0]             beat_lanes,
   output logic [WIDE_WORDS*WORD_W-1:0] rsp_data
);

   localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1;

   for (genvar l = 0; l < WIDE_WORDS; l++) begin : g_lane
      logic [BSEL_W-1:0] sel;
      logic [WORD_W-1:0] lane_d;
      always_comb begin
         sel    = BSEL_W'((32'(beat_off) + l) % BANKS);
         lane_d = (beat_valid && (32'(beat_lanes) > l)) ? bank_q[sel] : '0;
      end
      assign rsp_data[l*WORD_W +: WORD_W] = lane_d;
   end

endmodule

// File: rtl/mem_refill_engine.sv
module mem_refill_engine
   import mrf_pkg::*;
#(
   parameter int WORD_W       = 32,
   parameter int BLK_WORDS    = 4,
   parameter int WIDE_WORDS   = 2,
   parameter int BANKS        = 4,
   parameter int DEPTH_BLOCKS = 16,
   parameter int ADDR_CYC     = 1,
   parameter int ACCESS_CYC   = 15,
   parameter int XFER_CYC     = 1,
   localparam int BLK_AW      = (DEPTH_BLOCKS > 1) ? $clog2(DEPTH_BLOCKS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [BLK_AW-1:0]            req_blk,
   input  logic [1:0]                   req_mode,
   output logic                         rsp_valid,
   output logic [WIDE_WORDS*WORD_W-1:0] rsp_data,
   output logic                         rsp_done
);

   localparam int STRIPES = BLK_WORDS / BANKS;
   localparam int ROWS    = DEPTH_BLOCKS * STRIPES;
   localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int OFF_W   = $clog2(BLK_WORDS + 1);
   localparam int CYC_MAX = (ACCESS_CYC > ADDR_CYC)
                          ? ((ACCESS_CYC > XFER_CYC) ? ACCESS_CYC : XFER_CYC)
                          : ((ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC);
   localparam int CNT_W   = (CYC_MAX > 1) ? $clog2(CYC_MAX) : 1;

   // Elaboration-time parameter checks
   if (BLK_WORDS % BANKS != 0) begin : g_chk_banks
      $error("BLK_WORDS must be a multiple of BANKS");
   end
   if (WIDE_WORDS < 1 || BANKS % WIDE_WORDS != 0) begin : g_chk_wide
      $error("WIDE_WORDS must divide BANKS");
   end
   if (ADDR_CYC < 1 || ACCESS_CYC < 1 || XFER_CYC < 1) begin : g_chk_cyc
      $error("phase lengths must be at least one cycle");
   end
   if ((1 << BLK_AW) != DEPTH_BLOCKS) begin : g_chk_depth
      $error("DEPTH_BLOCKS must be a power of two");
   end

   logic              beat_valid;
   logic              beat_last;
   logic [OFF_W-1:0]  beat_off;
   logic [OFF_W-1:0]  beat_lanes;
   logic              cap_en;
   logic [ROW_W-1:0]  cap_row;
   logic [WORD_W-1:0] bank_q [BANKS];

   mrf_seq #(
      .BLK_WORDS  (BLK_WORDS),
      .WIDE_WORDS (WIDE_WORDS),
      .BANKS      (BANKS),
      .ADDR_CYC   (ADDR_CYC),
      .ACCESS_CYC (ACCESS_CYC),
      .XFER_CYC   (XFER_CYC),
      .BLK_AW     (BLK_AW),
      .ROW_W      (ROW_W),
      .OFF_W      (OFF_W),
      .CNT_W      (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_blk    (req_blk),
      .req_mode   (req_mode),
      .req_ready  (req_ready),
      .beat_valid (beat_valid),
      .beat_last  (beat_last),
      .beat_off   (beat_off),
      .beat_lanes (beat_lanes),
      .cap_en     (cap_en),
      .cap_row    (cap_row)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      mrf_bank #(
         .WORD_W  (WORD_W),
         .ROWS    (ROWS),
         .ROW_W   (ROW_W),
         .BANK_ID (b),
         .BANKS   (BANKS)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .cap_en  (cap_en),
         .cap_row (cap_row),
         .bank_q  (bank_q[b])
      );
   end

   mrf_lane_mux #(
      .WORD_W     (WORD_W),
      .WIDE_WORDS (WIDE_WORDS),
      .BANKS      (BANKS),
      .OFF_W      (OFF_W)
   ) u_mux (
      .bank_q     (bank_q),
      .beat_valid (beat_valid),
      .beat_off   (beat_off),
      .beat_lanes (beat_lanes),
      .rsp_data   (rsp_data)
   );

   assign rsp_valid = beat_valid;
   assign rsp_done  = beat_last;

   // R2: no transfer while idle
   p_valid_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   // R7: done only accompanies a transfer
   p_done_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> rsp_valid);

   // R9: the result bus is quiet between transfers
   p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_data == '0));

endmodule

// File: tb/mem_refill_engine_tb.sv
`timescale 1ns/1ps
module mem_refill_engine_tb;

   localparam int WW   = 32;
   localparam int BLK  = 4;
   localparam int WIDE = 2;
   localparam int NB   = 4;
   localparam int DEP  = 16;
   localparam int TA   = 1;
   localparam int TC   = 15;
   localparam int TX   = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [3:0]        req_blk = '0;
   logic [1:0]        req_mode = '0;
   logic              rsp_valid;
   logic [WIDE*WW-1:0] rsp_data;
   logic              rsp_done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mem_refill_engine #(
      .WORD_W(WW), .BLK_WORDS(BLK), .WIDE_WORDS(WIDE), .BANKS(NB),
      .DEPTH_BLOCKS(DEP), .ADDR_CYC(TA), .ACCESS_CYC(TC), .XFER_CYC(TX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_blk(req_blk), .req_mode(req_mode), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_done(rsp_done)
   );

   function automatic logic [31:0] pat(input int wa);
      logic [31:0] w;
      w = 32'(wa);
      return (w * 32'h9E37_79B1) ^ 32'h0F0F_0F0F;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !rsp_valid && !rsp_done && rsp_data == '0, "R1", "reset state",
            {rsp_data, req_ready, rsp_valid, rsp_done}, {64'h0, 3'b100});
   endtask

   // One refill: schedule computed from the organization formulas.
   task automatic t_refill(input logic [1:0] mode, input int blk, input bit poke,
                           input string req);
      int g_sz, ln, xpg, nb, t, bi, total;
      int ecyc[16];
      int eoff[16];
      int em;
      em = (mode == 2'd3) ? 0 : int'(mode);
      g_sz = (em == 1) ? WIDE : (em == 2) ? NB : 1;
      ln   = (em == 1) ? WIDE : 1;
      xpg  = g_sz / ln;
      nb = 0;
      t  = TA;
      for (int g = 0; g < BLK / g_sz; g++) begin
         t += TC;
         for (int x = 0; x < xpg; x++) begin
            t += TX;
            ecyc[nb] = t;
            eoff[nb] = g * g_sz + x * ln;
            nb++;
         end
      end
      total = t;
      @(negedge clk);
      check(req_ready, "R2", "ready before request", {127'h0, req_ready}, 128'h1);
      req_mode  = mode;
      req_blk   = 4'(blk);
      req_valid = 1'b1;
      @(posedge clk);
      bi = 0;
      for (int n = 1; n <= total + 1; n++) begin
         logic exp_v, exp_d;
         logic [WIDE*WW-1:0] exp_data;
         @(negedge clk);
         if (n == 1) begin
            req_valid = 1'b0;
            check(!req_ready, "R2", "busy after accept", {127'h0, req_ready}, 128'h0);
         end
         if (poke && n == 3) begin
            req_valid = 1'b1;
            req_blk   = 4'(blk ^ 1);
            req_mode  = (mode == 2'd1) ? 2'd2 : 2'd1;
         end
         if (poke && n == 6) req_valid = 1'b0;
         exp_v = (bi < nb) && (ecyc[bi] == n);
         exp_d = exp_v && (bi == nb - 1);
         exp_data = '0;
         if (exp_v) begin
            for (int l = 0; l < ln; l++) begin
               exp_data[l*WW +: WW] = pat(blk * BLK + eoff[bi] + l);
            end
            bi++;
         end
         check(rsp_valid == exp_v && rsp_done == exp_d && rsp_data == exp_data,
               req, $sformatf("cycle %0d beat/data", n),
               {rsp_data, rsp_valid, rsp_done}, {exp_data, exp_v, exp_d});
         if (n == total + 1) begin
            check(req_ready, "R11", "ready after done", {127'h0, req_ready}, 128'h1);
         end
      end
   endtask

   // R2: a request offered during a refill must not start another one
   task automatic t_idle_after(input int cycles);
      for (int n = 0; n < cycles; n++) begin
         @(negedge clk);
         check(req_ready && !rsp_valid, "R2", "ignored request left no refill",
               {126'h0, req_ready, rsp_valid}, {126'h0, 2'b10});
      end
   endtask

   initial begin
      t_reset();
      t_refill(2'd0, 5, 1'b0, "R3");   // narrow: 17/33/49/65
      t_refill(2'd1, 3, 1'b0, "R4");   // wide: 17/33, two lanes
      t_refill(2'd2, 15, 1'b0, "R5");  // interleaved: 17..20
      t_refill(2'd3, 0, 1'b0, "R8");   // spare code as narrow
      t_refill(2'd1, 9, 1'b1, "R10");  // mid-refill request and mode change
      t_idle_after(12);
      t_refill(2'd2, 6, 1'b1, "R10");
      t_idle_after(12);
      t_refill(2'd0, 12, 1'b0, "R6");  // contents of another block
      t_refill(2'd2, 1, 1'b0, "R7");   // back-to-back refills
      t_refill(2'd1, 14, 1'b0, "R9");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule